// File: doc/BRIEF.md
# Dual Register-Pair Transfer Unit

This block decodes and executes one instruction that copies two 32-bit words at once between a 16-entry general-purpose register file and a 32-entry single-precision register file. The direction can be either way. The unit holds both register files. On each valid input it decides three things: whether the word is this transfer, whether the register combination or the floating-point enable makes it undefined, and whether it should commit. Both destination writes land on the same clock edge.

Each instruction is presented for one cycle with `in_valid` high. The caller supplies the result of its own condition evaluation on `cond_ok` and the floating-point access permission on `fp_en`. `split_mode` selects which of two encodings applies: a plain 32-bit word that carries a condition field, or a word built from two halfwords that carries a fixed prefix. The field layout below bit 23 is the same in both encodings. One test read port per register file exposes the contents. Each file resets to a computed pattern, so a transfer always has known data to move.

Top module: `pair_xfer_unit`

## Requirements
- R1: With `split_mode`=0, the word is recognised (`match_o`=1) only if all of these hold: bits 31:28 are not 1111, bits 27:23 are 11000, bit 22 is 1, bit 21 is 0, bits 11:8 are 1010, bits 7:6 are 00 and bit 4 is 1. Any other word gives `match_o`=0, `undef_o`=0 and changes no register.
- R2: With `split_mode`=1, bits 31:23 must equal 111011000 and bits 22:0 must satisfy the same fixed-bit rules as in R1. Any other word gives `match_o`=0, `undef_o`=0 and changes no register.
- R3: When bit 20 is 1 and the transfer commits, the general-purpose entry at bits 15:12 (Rt) receives S[m] and the entry at bits 19:16 (Rt2) receives S[m+1]. The index m is {bits 3:0, bit 5}. Both writes become visible after the same single clock edge.
- R4: When bit 20 is 0 and the transfer commits, S[m] receives R[Rt] and S[m+1] receives R[Rt2]. Rt and Rt2 may be any two entries, including non-adjacent ones.
- R5: A recognised, condition-passing word with Rt=15, Rt2=15 or m=31 raises `undef_o` and leaves both files unchanged.
- R6: In the to-general direction, Rt equal to Rt2 raises `undef_o` and changes nothing. In the to-single direction, equal Rt and Rt2 is legal and writes the same value into S[m] and S[m+1].
- R7: A recognised, condition-passing word with `fp_en`=0 raises `undef_o` and changes nothing.
- R8: A recognised word with `cond_ok`=0 retires as a no-op: `match_o`=1, `undef_o`=0, and no register changes, even when its fields are illegal.
- R9: `done_o` is high in exactly the cycle after each cycle with `in_valid`=1, whatever the data, direction or outcome. `match_o` and `undef_o` are reported in that same cycle and are 0 whenever `done_o` is 0. Back-to-back inputs are accepted every cycle, and each one sees the results of the one before it.
- R10: After reset, `done_o`, `match_o` and `undef_o` are 0. General-purpose entry i holds 32'h1000_0000 + i*32'h0001_0011. Single-precision entry j holds 32'h8000_0000 + j*32'h0100_0003.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An instruction word is presented this cycle |
| instr | input | 32 | Instruction word |
| split_mode | input | 1 | 0: plain encoding, 1: two-halfword encoding |
| cond_ok | input | 1 | The instruction's condition passed |
| fp_en | input | 1 | Floating-point register access is permitted |
| gp_rd_addr | input | 4 | Test read address, general-purpose file |
| sp_rd_addr | input | 5 | Test read address, single-precision file |
| gp_rd_data | output | 32 | Test read data, general-purpose file (combinational) |
| sp_rd_data | output | 32 | Test read data, single-precision file (combinational) |
| match_o | output | 1 | The last input was recognised as this transfer |
| undef_o | output | 1 | The last input was undefined |
| done_o | output | 1 | One-cycle retirement pulse |

## Verification
The assertions rely on two things about the inputs: `in_valid`, `cond_ok`, `fp_en`, `split_mode` and `instr` are stable around each rising edge, and they are never unknown once reset has been released. The stimulus changes every input a fixed delay after the rising edge and keeps all of them at defined values from time zero. Both files are checked against a behavioural model through the test read ports. This covers legal transfers, illegal transfers, FP-disabled, condition-failed and unrecognised words. The read ports sweep every entry after each group, so a write that should not happen shows up in the entry it touched.

// File: rtl/pxu_pkg.sv
package pxu_pkg;

    localparam int WORD_W = 32;
    localparam int GP_N   = 16;
    localparam int SP_N   = 32;
    localparam int GP_AW  = $clog2(GP_N);
    localparam int SP_AW  = $clog2(SP_N);

    // prefix checks for the two encodings
    localparam logic [4:0] PLAIN_OPC  = 5'b11000;
    localparam logic [3:0] PLAIN_NV   = 4'b1111;
    localparam logic [8:0] SPLIT_PFX  = 9'b111011000;

    typedef struct packed {
        logic             hit;
        logic             to_gp;
        logic [GP_AW-1:0] rt;
        logic [GP_AW-1:0] rt2;
        logic [SP_AW-1:0] sm;
        logic             bad;
    } xfer_dec_t;

    typedef struct packed {
        logic done;
        logic hit;
        logic undef;
    } flag_t;

endpackage

// File: rtl/pxu_decode.sv
module pxu_decode
    import pxu_pkg::*;
(
    input  logic [WORD_W-1:0] instr,
    input  logic              split_mode,
    output xfer_dec_t         dec
);

    logic prefix_ok;
    logic body_ok;
    logic gp_last_used;
    logic sp_last_used;

    always_comb begin
        if (split_mode) begin
            prefix_ok = (instr[31:23] == SPLIT_PFX);
        end else begin
            prefix_ok = (instr[31:28] != PLAIN_NV) && (instr[27:23] == PLAIN_OPC);
        end

        body_ok = instr[22] && !instr[21] && (instr[11:8] == 4'b1010)
                  && (instr[7:6] == 2'b00) && instr[4];

        dec.hit   = prefix_ok && body_ok;
        dec.to_gp = instr[20];
        dec.rt2   = instr[19:16];
        dec.rt    = instr[15:12];
        dec.sm    = {instr[3:0], instr[5]};

        gp_last_used = (dec.rt == GP_AW'(GP_N - 1)) || (dec.rt2 == GP_AW'(GP_N - 1));
        sp_last_used = (dec.sm == SP_AW'(SP_N - 1));
        dec.bad      = gp_last_used || sp_last_used || (dec.to_gp && (dec.rt == dec.rt2));
    end

endmodule

// File: rtl/pxu_regfile.sv
module pxu_regfile #(
    parameter int              DEPTH = 16,
    parameter int              W     = 32,
    parameter int              NRD   = 3,
    parameter logic [W-1:0]    SEED  = '0,
    parameter logic [W-1:0]    STEP  = 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we_a,
    input  logic [$clog2(DEPTH)-1:0]      addr_a,
    input  logic [W-1:0]                  data_a,
    input  logic                          we_b,
    input  logic [$clog2(DEPTH)-1:0]      addr_b,
    input  logic [W-1:0]                  data_b,
    input  logic [NRD-1:0][$clog2(DEPTH)-1:0] rd_addr,
    output logic [NRD-1:0][W-1:0]         rd_data
);

    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem_q [DEPTH];
    logic [W-1:0] mem_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we_a) begin
            mem_d[addr_a] = data_a;
        end
        if (we_b) begin
            mem_d[addr_b] = data_b;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= SEED + W'(i) * STEP;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        logic [AW-1:0] a;
        assign a          = rd_addr[p];
        assign rd_data[p] = mem_q[a];
    end

endmodule

// File: rtl/pair_xfer_unit.sv
module pair_xfer_unit
    import pxu_pkg::*;
#(
    parameter logic [31:0] GP_SEED = 32'h1000_0000,
    parameter logic [31:0] GP_STEP = 32'h0001_0011,
    parameter logic [31:0] SP_SEED = 32'h8000_0000,
    parameter logic [31:0] SP_STEP = 32'h0100_0003
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [31:0] instr,
    input  logic        split_mode,
    input  logic        cond_ok,
    input  logic        fp_en,
    input  logic [3:0]  gp_rd_addr,
    input  logic [4:0]  sp_rd_addr,
    output logic [31:0] gp_rd_data,
    output logic [31:0] sp_rd_data,
    output logic        match_o,
    output logic        undef_o,
    output logic        done_o
);

    localparam int NRD = 3;

    xfer_dec_t dec;
    flag_t     flags_d, flags_q;
    logic      commit;
    logic [SP_AW-1:0] sm_next;

    logic [NRD-1:0][GP_AW-1:0]  gp_ra;
    logic [NRD-1:0][WORD_W-1:0] gp_rd;
    logic [NRD-1:0][SP_AW-1:0]  sp_ra;
    logic [NRD-1:0][WORD_W-1:0] sp_rd;

    logic gp_we, sp_we;

    pxu_decode u_dec (
        .instr      (instr),
        .split_mode (split_mode),
        .dec        (dec)
    );

    always_comb begin
        sm_next = dec.sm + SP_AW'(1);
        commit  = in_valid && cond_ok && fp_en && dec.hit && !dec.bad;
        gp_we   = commit && dec.to_gp;
        sp_we   = commit && !dec.to_gp;

        gp_ra[0] = dec.rt;
        gp_ra[1] = dec.rt2;
        gp_ra[2] = gp_rd_addr;
        sp_ra[0] = dec.sm;
        sp_ra[1] = sm_next;
        sp_ra[2] = sp_rd_addr;

        flags_d.done  = in_valid;
        flags_d.hit   = in_valid && dec.hit;
        flags_d.undef = in_valid && dec.hit && cond_ok && (!fp_en || dec.bad);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    pxu_regfile #(
        .DEPTH (GP_N),
        .W     (WORD_W),
        .NRD   (NRD),
        .SEED  (GP_SEED),
        .STEP  (GP_STEP)
    ) u_gp (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_a    (gp_we),
        .addr_a  (dec.rt),
        .data_a  (sp_rd[0]),
        .we_b    (gp_we),
        .addr_b  (dec.rt2),
        .data_b  (sp_rd[1]),
        .rd_addr (gp_ra),
        .rd_data (gp_rd)
    );

    pxu_regfile #(
        .DEPTH (SP_N),
        .W     (WORD_W),
        .NRD   (NRD),
        .SEED  (SP_SEED),
        .STEP  (SP_STEP)
    ) u_sp (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_a    (sp_we),
        .addr_a  (dec.sm),
        .data_a  (gp_rd[0]),
        .we_b    (sp_we),
        .addr_b  (sm_next),
        .data_b  (gp_rd[1]),
        .rd_addr (sp_ra),
        .rd_data (sp_rd)
    );

    assign gp_rd_data = gp_rd[2];
    assign sp_rd_data = sp_rd[2];
    assign done_o     = flags_q.done;
    assign match_o    = flags_q.hit;
    assign undef_o    = flags_q.undef;

endmodule

// File: rtl/pxu_checker.sv
module pxu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] instr,
    input logic        split_mode,
    input logic        cond_ok,
    input logic        fp_en,
    input logic        match_o,
    input logic        undef_o,
    input logic        done_o
);

    // R9
    done_follows_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> done_o);

    // R9
    no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !done_o);

    // R9
    flags_need_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> (!match_o && !undef_o));

    // R5
    undef_implies_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        undef_o |-> match_o);

    // R8
    cond_fail_no_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cond_ok) |=> !undef_o);

    // R7
    fp_off_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond_ok && !fp_en) |=> (match_o == undef_o));

    // R1
    plain_nv_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !split_mode && (instr[31:28] == 4'b1111)) |=> !match_o);

endmodule

bind pair_xfer_unit pxu_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .instr      (instr),
    .split_mode (split_mode),
    .cond_ok    (cond_ok),
    .fp_en      (fp_en),
    .match_o    (match_o),
    .undef_o    (undef_o),
    .done_o     (done_o)
);

// File: tb/sim_pair_xfer_unit.sv
`timescale 1ns/1ps
module sim_pair_xfer_unit;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic        split_mode = 1'b0;
    logic        cond_ok = 1'b1;
    logic        fp_en = 1'b1;
    logic [3:0]  gp_rd_addr = '0;
    logic [4:0]  sp_rd_addr = '0;
    logic [31:0] gp_rd_data, sp_rd_data;
    logic        match_o, undef_o, done_o;

    int    errors = 0;
    int    checks = 0;
    bit    model_ok = 0;
    bit    finished = 0;
    string cur_req = "R10";

    // reference state
    logic [31:0] m_gp [16];
    logic [31:0] m_sp [32];
    logic        e_done, e_match, e_undef;

    always #(CLK_PERIOD/2) clk = ~clk;

    pair_xfer_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .split_mode(split_mode), .cond_ok(cond_ok), .fp_en(fp_en),
        .gp_rd_addr(gp_rd_addr), .sp_rd_addr(sp_rd_addr),
        .gp_rd_data(gp_rd_data), .sp_rd_data(sp_rd_data),
        .match_o(match_o), .undef_o(undef_o), .done_o(done_o)
    );

    // behavioural reference, updated on every edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) m_gp[i] = 32'h1000_0000 + i * 32'h0001_0011;
            for (int j = 0; j < 32; j++) m_sp[j] = 32'h8000_0000 + j * 32'h0100_0003;
            e_done = 0; e_match = 0; e_undef = 0;
            model_ok = 1;
        end else begin
            int t, t2, m, m1;
            bit recog, illegal, tog;
            logic [31:0] a, b;
            t   = int'(instr[15:12]);
            t2  = int'(instr[19:16]);
            m   = int'(instr[3:0]) * 2 + int'(instr[5]);
            m1  = (m + 1) % 32;
            tog = instr[20];
            recog = (split_mode ? (instr[31:23] == 9'h1D8)
                                : (instr[31:28] != 4'hF && instr[27:23] == 5'h18))
                    && instr[22] == 1'b1 && instr[21] == 1'b0 && instr[11:8] == 4'hA
                    && instr[7:6] == 2'b00 && instr[4] == 1'b1;
            illegal = (t == 15) || (t2 == 15) || (m == 31) || (tog && t == t2);
            e_done  = in_valid;
            e_match = in_valid && recog;
            e_undef = in_valid && recog && cond_ok && (!fp_en || illegal);
            if (in_valid && recog && cond_ok && fp_en && !illegal) begin
                if (tog) begin
                    a = m_sp[m]; b = m_sp[m1];
                    m_gp[t] = a; m_gp[t2] = b;
                end else begin
                    a = m_gp[t]; b = m_gp[t2];
                    m_sp[m] = a; m_sp[m1] = b;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (model_ok && !finished) begin
            chk(done_o === e_done, "R9", "done", 32'(done_o), 32'(e_done));
            chk(match_o === e_match, cur_req, "match", 32'(match_o), 32'(e_match));
            chk(undef_o === e_undef, cur_req, "undef", 32'(undef_o), 32'(e_undef));
            chk(gp_rd_data === m_gp[gp_rd_addr], cur_req, "gp read", gp_rd_data, m_gp[gp_rd_addr]);
            chk(sp_rd_data === m_sp[sp_rd_addr], cur_req, "sp read", sp_rd_data, m_sp[sp_rd_addr]);
        end
    end

    function automatic logic [31:0] enc(input bit split, input bit op, input int rt2,
                                        input int rt, input int m, input logic [3:0] cnd);
        logic [31:0] w;
        logic [4:0]  mm;
        mm = 5'(m);
        w = {cnd, 5'b11000, 1'b1, 1'b0, op, 4'(rt2), 4'(rt), 4'b1010, 2'b00, mm[0], 1'b1, mm[4:1]};
        if (split) w[31:23] = 9'b111011000;
        return w;
    endfunction

    task automatic drive(input logic [31:0] w, input bit split, input bit c, input bit f);
        @(posedge clk); #2;
        in_valid = 1; instr = w; split_mode = split; cond_ok = c; fp_en = f;
    endtask

    task automatic idle();
        @(posedge clk); #2;
        in_valid = 0;
    endtask

    task automatic issue(input logic [31:0] w, input bit split, input bit c, input bit f);
        drive(w, split, c, f);
        idle();
    endtask

    task automatic sweep();
        for (int i = 0; i < 32; i++) begin
            @(posedge clk); #2;
            in_valid = 0;
            gp_rd_addr = 4'(i % 16);
            sp_rd_addr = 5'(i);
        end
        @(posedge clk); #2;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #2 rst_n = 1;
        cur_req = "R10";
        sweep();

        cur_req = "R4";
        issue(enc(0, 0, 7, 3, 10, 4'hE), 0, 1, 1);
        issue(enc(0, 0, 0, 12, 1, 4'h3), 0, 1, 1);
        sweep();

        cur_req = "R3";
        issue(enc(0, 1, 2, 1, 10, 4'hE), 0, 1, 1);
        issue(enc(0, 1, 9, 14, 0, 4'h0), 0, 1, 1);
        sweep();

        cur_req = "R2";
        issue(enc(1, 1, 0, 4, 30, 4'h0), 1, 1, 1);
        issue(enc(1, 0, 8, 5, 20, 4'h0), 1, 1, 1);
        issue(enc(0, 0, 8, 5, 20, 4'h0), 1, 1, 1);
        sweep();

        cur_req = "R6";
        issue(enc(1, 0, 5, 5, 0, 4'h0), 1, 1, 1);
        issue(enc(0, 1, 6, 6, 4, 4'hE), 0, 1, 1);
        sweep();

        cur_req = "R5";
        issue(enc(0, 0, 2, 15, 6, 4'hE), 0, 1, 1);
        issue(enc(0, 1, 15, 3, 6, 4'hE), 0, 1, 1);
        issue(enc(0, 0, 2, 3, 31, 4'hE), 0, 1, 1);
        sweep();

        cur_req = "R7";
        issue(enc(0, 0, 2, 3, 12, 4'hE), 0, 1, 0);
        issue(enc(1, 1, 2, 3, 12, 4'h0), 1, 1, 0);
        sweep();

        cur_req = "R8";
        issue(enc(0, 0, 2, 3, 12, 4'h1), 0, 0, 1);
        issue(enc(0, 1, 4, 4, 31, 4'h1), 0, 0, 0);
        sweep();

        cur_req = "R1";
        issue(enc(0, 0, 2, 3, 12, 4'hF), 0, 1, 1);
        issue(enc(0, 0, 2, 3, 12, 4'hE) | 32'h0020_0000, 0, 1, 1);
        issue(enc(0, 0, 2, 3, 12, 4'hE) & ~32'h0000_0010, 0, 1, 1);
        issue(enc(0, 0, 2, 3, 12, 4'hE) | 32'h0000_00C0, 0, 1, 1);
        sweep();

        cur_req = "R9";
        drive(enc(0, 0, 9, 8, 16, 4'hE), 0, 1, 1);
        drive(enc(0, 1, 1, 0, 16, 4'hE), 0, 1, 1);
        drive(enc(1, 0, 0, 1, 2, 4'h0), 1, 1, 1);
        drive(enc(0, 0, 2, 3, 31, 4'hE), 0, 1, 1);
        drive(enc(0, 0, 2, 3, 12, 4'hF), 0, 1, 1);
        idle();
        sweep();

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule